// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block lets a synchronous host read and write an external asynchronous static RAM of 32K words by 8 bits. The host raises a request with an address, a write flag and write data, and holds it until a one-clock acknowledge. The controller then runs one complete memory cycle on the RAM pins and returns to idle. The RAM pins are the address bus, an active-low and an active-high chip select, an active-low write strobe, and a split data path. The split data path carries outgoing data, an output enable for the board's tristate driver, and incoming data.

All waits come from nanosecond figures turned into clock counts by ceiling division at elaboration. At the default 20 ns clock and 55 ns timing the counts are:

| Wait | Cycles |
|---|---|
| Read access | 3 |
| Bus turnaround | 1 |
| Data setup | 2 |
| Effective strobe low time | 3 (the larger of the pulse width and turnaround plus setup) |
| Padding after each access | 1 |
| Standby wake-up | 3 |

A standby input keeps the chip deselected. After standby falls, the controller waits one full memory cycle time before it selects the chip again.

Top module: `sram_seq_ctrl`

## Requirements
- R1: After a synchronous reset, the controller shows an idle memory side: active-low select high, active-high select low, strobe high, driver off. The acknowledge is low.
- R2: A write selects the chip with the strobe high for exactly one cycle before the strobe falls. The strobe is low only while both selects are active.
- R3: The strobe stays low for the effective strobe count (3 cycles by default), then rises in the same cycle that both selects are released.
- R4: The data driver turns on after the turnaround count of strobe-low cycles (1 by default). It stays on through the cycle in which the strobe has risen and turns off the cycle after. It is never on while the chip is selected with the strobe high.
- R5: A read selects the chip for the access count (3 cycles by default) with the strobe high and the driver off. The bus value at the end of that window appears on the read-data output.
- R6: The address bus does not change while the chip is selected, and it holds the address latched when the request was accepted.
- R7: After every access the chip stays deselected for the padding count (1 cycle by default). Then the acknowledge is high for exactly one cycle. From the first selected cycle, the acknowledge comes 6 cycles later for a write and 4 cycles later for a read.
- R8: A request is accepted only in idle with the acknowledge low. Address and write data are latched at acceptance, so host inputs that change afterwards do not affect the cycle in progress.
- R9: While standby is high, no request is accepted and the chip stays deselected. A cycle already under way completes normally and is acknowledged.
- R10: After standby falls, no select occurs for the wake-up count (3 cycles by default). A request held across the fall is accepted on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| standby | input | 1 | Hold the RAM deselected |
| req | input | 1 | Host request, held until ack |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 15 | Host word address |
| wdata | input | 8 | Host write data |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Data from the last read |
| mem_addr | output | 15 | RAM address bus |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_dq_oe | output | 1 | Enable for the data bus driver |
| mem_dq_out | output | 8 | Data driven to the RAM |
| mem_dq_in | input | 8 | Data read from the RAM bus |

## Verification
The hardest case to reach is the interplay of standby with a request. Standby can rise while a cycle is already in flight, and it can fall while a request is being held. The bench reaches the first case by raising standby two cycles after acceptance and checking that the cycle is still acknowledged. It reaches the second by holding a request through a standby period and dropping standby in the same cycle, then measuring how many cycles pass before the first select. A RAM model in the bench returns garbage until the access count has elapsed, and it stores a value only when the driver is on at the strobe's rising edge. A short access window or a late driver therefore shows up in read-back data.

// File: rtl/sram_seq_ctrl.sv
`timescale 1ns/1ps
module sram_seq_ctrl #(
  parameter int AW      = 15,
  parameter int DW      = 8,
  parameter int CLK_NS  = 20,
  parameter int ACC_NS  = 55,
  parameter int WP_NS   = 40,
  parameter int DSU_NS  = 25,
  parameter int TURN_NS = 20,
  parameter int PAD_NS  = 20,
  parameter int CYC_NS  = 55
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          standby,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          ack,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_sel_n,
  output logic          mem_sel,
  output logic          mem_wr_n,
  output logic          mem_dq_oe,
  output logic [DW-1:0] mem_dq_out,
  input  logic [DW-1:0] mem_dq_in
);
  localparam int ACC_C  = (ACC_NS + CLK_NS - 1) / CLK_NS;
  localparam int CYC_C  = (CYC_NS + CLK_NS - 1) / CLK_NS;
  localparam int WP_C   = (WP_NS + CLK_NS - 1) / CLK_NS;
  localparam int DSU_R  = (DSU_NS + CLK_NS - 1) / CLK_NS;
  localparam int DSU_C  = (DSU_R < 1) ? 1 : DSU_R;
  localparam int TURN_C = (TURN_NS + CLK_NS - 1) / CLK_NS;
  localparam int PAD_C  = (PAD_NS + CLK_NS - 1) / CLK_NS;
  localparam int RD_C   = (ACC_C > CYC_C) ? ACC_C : CYC_C;
  localparam int WPE_C  = (WP_C > TURN_C + DSU_C) ? WP_C : TURN_C + DSU_C;
  localparam int WAKE_C = CYC_C;
  localparam int MX1    = (RD_C > WPE_C) ? RD_C : WPE_C;
  localparam int MAXC   = (MX1 > PAD_C) ? MX1 : PAD_C;
  localparam int CW     = $clog2(MAXC + 1);
  localparam int KW     = $clog2(WAKE_C + 1);
  localparam logic [CW-1:0] OE_AT = CW'(WPE_C - 1 - TURN_C);

  if (CLK_NS < 1 || ACC_NS < 1 || WP_NS < 1 || TURN_NS < 1 || PAD_NS < 1 || CYC_NS < 1 || DSU_NS < 0)
    begin : g_bad_timing
      $error("sram_seq_ctrl: timing figures must be positive");
    end

  typedef enum logic [2:0] {ST_IDLE, ST_WSET, ST_WSTB, ST_WREL, ST_RACC, ST_PAD} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [KW-1:0] wake;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdat_q;
  logic          sel_on;
  logic          take;

  assign sel_on     = (st == ST_WSET) || (st == ST_WSTB) || (st == ST_RACC);
  assign mem_sel_n  = ~sel_on;
  assign mem_sel    = sel_on;
  assign mem_wr_n   = (st != ST_WSTB);
  assign mem_dq_oe  = ((st == ST_WSTB) && (cnt <= OE_AT)) || (st == ST_WREL);
  assign mem_addr   = addr_q;
  assign mem_dq_out = wdat_q;
  assign take       = req && !standby && (wake == '0) && !ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      wake   <= '0;
      ack    <= 1'b0;
      addr_q <= '0;
      wdat_q <= '0;
      rdata  <= '0;
    end else begin
      ack <= 1'b0;
      if (standby)           wake <= KW'(WAKE_C);
      else if (wake != '0)   wake <= wake - 1'b1;
      case (st)
        ST_IDLE: if (take) begin
          addr_q <= addr;
          wdat_q <= wdata;
          if (we) st <= ST_WSET;
          else begin
            st  <= ST_RACC;
            cnt <= CW'(RD_C - 1);
          end
        end
        ST_WSET: begin
          st  <= ST_WSTB;
          cnt <= CW'(WPE_C - 1);
        end
        ST_WSTB: if (cnt == '0) st <= ST_WREL;
                 else cnt <= cnt - 1'b1;
        ST_WREL: begin
          st  <= ST_PAD;
          cnt <= CW'(PAD_C - 1);
        end
        ST_RACC: if (cnt == '0) begin
          rdata <= mem_dq_in;
          st    <= ST_PAD;
          cnt   <= CW'(PAD_C - 1);
        end else cnt <= cnt - 1'b1;
        ST_PAD: if (cnt == '0) begin
          st  <= ST_IDLE;
          ack <= 1'b1;
        end else cnt <= cnt - 1'b1;
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_STB_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    !mem_wr_n |-> (!mem_sel_n && mem_sel)); // R2
  AST_STB_PREARMED: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_wr_n) |-> $past(!mem_sel_n && mem_sel)); // R2
  AST_STB_SEL_END: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_wr_n) |-> (mem_sel_n && !mem_sel && mem_dq_oe)); // R3
  AST_OE_DROP: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_wr_n) |=> !mem_dq_oe); // R4
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> !(mem_sel && !mem_sel_n && mem_wr_n)); // R4
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    (mem_sel && $past(mem_sel)) |-> $stable(mem_addr)); // R6
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack); // R7
  AST_STANDBY_DESEL: assert property (@(posedge clk) disable iff (rst)
    (standby && mem_sel_n && !mem_dq_oe && !ack) |=> (mem_sel_n && !mem_sel)); // R9
endmodule

// File: tb/sram_seq_ctrl_test.sv
`timescale 1ns/1ps
module sram_seq_ctrl_test;
  localparam int WPE = 3, TRN = 1, RDC = 3, PADC = 1, WAKE = 3;

  logic clk = 1'b0, rst = 1'b1, standby = 1'b0, req = 1'b0, we = 1'b0;
  logic [14:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic ack, mem_sel_n, mem_sel, mem_wr_n, mem_dq_oe;
  logic [7:0]  rdata, mem_dq_out, mem_dq_in;
  logic [14:0] mem_addr;

  int total = 0, bad = 0;

  always #10 clk = ~clk;

  sram_seq_ctrl uut (
    .clk(clk), .rst(rst), .standby(standby), .req(req), .we(we), .addr(addr),
    .wdata(wdata), .ack(ack), .rdata(rdata), .mem_addr(mem_addr),
    .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_wr_n(mem_wr_n),
    .mem_dq_oe(mem_dq_oe), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in)
  );

  logic [7:0] ram [0:255];
  int rd_cnt = 0;
  wire selected = !mem_sel_n && mem_sel;

  always @(posedge mem_wr_n)
    if (selected === 1'b1 || (mem_sel_n === 1'b1 && mem_dq_oe === 1'b1))
      ram[mem_addr[7:0]] <= mem_dq_oe ? mem_dq_out : 8'hBD;
  always @(posedge clk) rd_cnt <= (selected && mem_wr_n) ? rd_cnt + 1 : 0;
  assign mem_dq_in = (selected && mem_wr_n && rd_cnt >= RDC - 1) ? ram[mem_addr[7:0]] : 8'hA5;

  logic sel_t [0:39];
  logic wrl_t [0:39];
  logic oe_t  [0:39];
  int   ack_n, first_sel;
  logic addr_bad, ack_after;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic w, input logic [14:0] a, input logic [7:0] d, input int stby_at);
    logic scr;
    scr = 1'b0; ack_n = 0; first_sel = 0; addr_bad = 1'b0;
    req = 1'b1; we = w; addr = a; wdata = d;
    for (int n = 0; n < 40; n++) begin sel_t[n] = 0; wrl_t[n] = 0; oe_t[n] = 0; end
    for (int n = 1; n < 40; n++) begin
      @(posedge clk); @(negedge clk);
      sel_t[n] = selected; wrl_t[n] = !mem_wr_n; oe_t[n] = mem_dq_oe;
      if (selected && first_sel == 0) first_sel = n;
      if (selected && mem_addr != a) addr_bad = 1'b1;
      if (selected && !scr) begin scr = 1'b1; addr = ~a; wdata = ~d; end
      if (n == stby_at) standby = 1'b1;
      if (ack) begin ack_n = n; break; end
    end
    req = 1'b0;
    @(posedge clk); @(negedge clk);
    ack_after = ack;
  endtask

  task automatic shape_write(input string lbl);
    int s;
    logic ok_sel, ok_wr, ok_oe;
    s = first_sel; ok_sel = 1; ok_wr = 1; ok_oe = 1;
    for (int n = 1; n < 40; n++) begin
      if (sel_t[n] != (n >= s && n <= s + WPE)) ok_sel = 0;
      if (wrl_t[n] != (n >= s + 1 && n <= s + WPE)) ok_wr = 0;
      if (oe_t[n] != (n >= s + 1 + TRN && n <= s + WPE + 1)) ok_oe = 0;
    end
    check(s != 0 && ok_sel && ok_wr, {"R2/R3 strobe and select window ", lbl}, ok_sel, 1);
    check(ok_oe, {"R4 driver window ", lbl}, ok_oe, 1);
    check(!addr_bad, {"R6 address held ", lbl}, addr_bad, 0);
    check(ack_n == s + WPE + 2 + PADC, {"R7 write ack latency ", lbl}, ack_n - s, WPE + 2 + PADC);
    check(!ack_after, {"R7 ack single pulse ", lbl}, ack_after, 0);
  endtask

  task automatic shape_read(input string lbl, input logic [7:0] exp);
    int s;
    logic ok;
    s = first_sel; ok = 1;
    for (int n = 1; n < 40; n++) begin
      if (sel_t[n] != (n >= s && n < s + RDC)) ok = 0;
      if (wrl_t[n] || oe_t[n]) ok = 0;
    end
    check(s != 0 && ok, {"R5 read window ", lbl}, ok, 1);
    check(rdata == exp, {"R5 read data ", lbl}, rdata, exp);
    check(!addr_bad, {"R6 read address ", lbl}, addr_bad, 0);
    check(ack_n == s + RDC + PADC, {"R7 read ack latency ", lbl}, ack_n - s, RDC + PADC);
  endtask

  task automatic t_reset;
    check(mem_sel_n && !mem_sel && mem_wr_n && !mem_dq_oe && !ack, "R1 idle after reset",
          {mem_sel_n, mem_sel, mem_wr_n, mem_dq_oe, ack}, 5'b10100);
  endtask

  task automatic t_write_read;
    xfer(1'b1, 15'h1234, 8'h5A, 0);
    shape_write("w1");
    check(ram[8'h34] == 8'h5A, "R8 latched data stored", ram[8'h34], 8'h5A);
    xfer(1'b0, 15'h1234, 8'h00, 0);
    shape_read("r1", 8'h5A);
  endtask

  task automatic t_patterns;
    xfer(1'b1, 15'h7FFF, 8'hFF, 0); shape_write("w7fff");
    xfer(1'b1, 15'h0000, 8'h00, 0); shape_write("w0000");
    xfer(1'b1, 15'h4180, 8'hC3, 0); shape_write("w4180");
    xfer(1'b0, 15'h7FFF, 8'h00, 0); shape_read("r7fff", 8'hFF);
    xfer(1'b0, 15'h0000, 8'h00, 0); shape_read("r0000", 8'h00);
    xfer(1'b0, 15'h4180, 8'h00, 0); shape_read("r4180", 8'hC3);
  endtask

  task automatic t_standby_idle;
    logic seen;
    seen = 1'b0;
    standby = 1'b1;
    req = 1'b1; we = 1'b0; addr = 15'h0034;
    for (int n = 0; n < 10; n++) begin
      @(posedge clk); @(negedge clk);
      if (selected || ack) seen = 1'b1;
    end
    check(!seen, "R9 no access during standby", seen, 0);
    standby = 1'b0;
    xfer(1'b0, 15'h0034, 8'h00, 0);
    check(first_sel == WAKE + 1, "R10 wake-up delay", first_sel, WAKE + 1);
    shape_read("wake", 8'h5A);
  endtask

  task automatic t_standby_inflight;
    xfer(1'b1, 15'h0099, 8'h3C, 2);
    check(ack_n != 0, "R9 in-flight write completes", ack_n, 1);
    shape_write("stby");
    check(ram[8'h99] == 8'h3C, "R9 in-flight data stored", ram[8'h99], 8'h3C);
    standby = 1'b0;
    repeat (WAKE + 1) @(negedge clk);
  endtask

  task automatic t_ack_hold;
    logic early;
    early = 1'b0;
    req = 1'b1; we = 1'b0; addr = 15'h0099;
    for (int n = 1; n < 40; n++) begin
      @(posedge clk); @(negedge clk);
      if (ack) break;
    end
    @(posedge clk); @(negedge clk);
    early = selected;
    check(!early, "R8 no accept in ack cycle", early, 0);
    @(posedge clk); @(negedge clk);
    check(selected, "R8 accept after ack with req held", selected, 1);
    req = 1'b0;
    for (int n = 1; n < 40; n++) begin
      @(posedge clk); @(negedge clk);
      if (ack) break;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) ram[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_write_read;
    t_patterns;
    t_standby_idle;
    t_standby_inflight;
    t_ack_hold;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule